// File: doc/BRIEF.md
# Multi-Stream SDI Line Number and Payload ID Inserter

This block sits on the transmit side of a multi-stream serial digital video link. It takes up to eight parallel 10-bit data streams that share one clock and a clock enable. After every end-of-active-video marker it writes the current line number into the two words that follow the marker. It then recomputes the 18-bit line CRC and puts it into the two words after the line number. Streams are grouped in luma/chroma pairs. Line number channel p serves the pair made of streams 2p+1 and 2p+2. Stream 2p+1 carries luma and stream 2p+2 carries chroma.

When payload identification is enabled, the block can also write an 11-word ancillary packet into the horizontal blanking. The packet goes directly after the CRC pair, on one of two programmable line numbers. It is written into the luma stream of each pair, and into the chroma stream as well when chroma insertion is switched on. Each pair has its own set of four luma user words and its own set of four chroma user words.

In eight-stream mode the clock enable is asserted on alternate cycles. In four-stream mode it stays high, and streams 5 to 8 pass through unchanged. The module does not interleave, serialize or scramble the streams, and it does not generate video timing.

Top module: `sdi_pid_inserter`

## Requirements
- R1: While reset is asserted, and after it until the first cycle with the clock enable high, every output stream word is 000h.
- R2: Each output word is registered and updates only on a clock edge where `ce` is 1. In that case it reflects the input word of the same edge, with one cycle of latency. When `ce` is 0 the outputs hold their value.
- R3: The block recognises an end-of-active-video marker as four words in a row on one stream: 3FFh, 000h, 000h and X, where bit 6 of X is 1. It samples line channel p (`ln_in[11p+10:11p]`) on the X word. When `ln_ok` is 1 it replaces the next two words on streams 2p+1 and 2p+2 with LN0 = {~L[6], L[6:0], 2'b00} and LN1 = {1'b1, 3'b000, L[10:7], 2'b00}. When `ln_ok` is 0 those two words pass through unchanged.
- R4: The two words after LN1 are replaced with CR0 = {~C[8], C[8:0]} and CR1 = {~C[17], C[17:9]}. C is an 18-bit CRC with polynomial x^18+x^5+x^4+1, processed LSB first: for each data bit, fb = C[0] ^ bit, then C shifts right by one and is XORed with 23000h when fb is 1. C starts at 0 after reset and again after each CR1 output. It covers every output word of the stream up to and including LN1.
- R5: The packet occupies the 11 words that follow CR1, in this order: 000h, 3FFh, 3FFh, 241h, 101h, 104h, U0, U1, U2, U3, CS. Each user byte u is written as {~^u, ^u, u}, with U0 taken from bits 7:0 of the channel's 32-bit user field and U3 from bits 31:24. CS is {~S[8], S[8:0]}, where S is the 9-bit sum of bits 8:0 of the words from 241h through U3.
- R6: Luma stream 2p+1 takes its user words from `uw_y[32p+31:32p]`. Chroma stream 2p+2 receives a packet only when `pid_c_en` is 1, and then takes its user words from `uw_c[32p+31:32p]`.
- R7: A packet is written only when all of the following hold: `pid_en` is 1, `ln_ok` is 1, and the sampled line number equals `pid_line_a` or `pid_line_b`. Otherwise the 11 slot words pass through unchanged.
- R8: The decision to write a packet is made on the first slot word. That word must be at blanking level (040h on luma streams, 200h on chroma streams). If it is not, the whole 11-word slot passes through unchanged.
- R9: When `mode8` is 0, streams 5 to 8 pass through unchanged, each with the same one-enable latency.
- R10: Every word that is not a line-number, CRC or packet word passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Word enable (always high with four streams, alternate cycles with eight) |
| mode8 | input | 1 | 1: eight streams in use; 0: four streams |
| ln_ok | input | 1 | Line-number channels carry valid values |
| pid_en | input | 1 | Enables payload ID packet insertion |
| pid_c_en | input | 1 | Also inserts packets into the chroma streams |
| pid_line_a | input | 11 | First line number that carries the packet |
| pid_line_b | input | 11 | Second line number that carries the packet |
| ln_in | input | 44 | Four 11-bit line numbers, channel p at bits 11p+10:11p |
| uw_y | input | 128 | Four luma user-word sets, 32 bits per channel |
| uw_c | input | 128 | Four chroma user-word sets, 32 bits per channel |
| din | input | 80 | Eight input streams, stream s+1 at bits 10s+9:10s |
| dout | output | 80 | Eight output streams, same layout |

## Verification
Some properties are checked by assertions on every cycle. These are: outputs hold while the enable is low; the upper streams pass through in four-stream mode; no slot word changes while insertion is disabled; and the inverted-bit-9 format of the line-number and CRC words. Other behaviour can only be shown by the bench's line-by-line scenarios, because each depends on the history of the stream. That covers the exact CRC value across many lines and across mode switches, the packet contents and checksum, the luma/chroma user-word mapping, the gating on line match and on the availability of line numbers, and the blanking-level check on the first slot word.

// File: rtl/sdi_pid_pkg.sv
package sdi_pid_pkg;
    localparam int WORD_W = 10;
    localparam int LN_W   = 11;
    localparam int CRC_W  = 18;
    localparam int UW_W   = 32;
    localparam int POS_W  = 5;
    localparam int PKT_LEN = 11;
    localparam int PIDX_W = 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [POS_W-1:0]  pos_t;

    // word positions counted from the first marker word
    localparam pos_t P_LN0 = 5'd4;
    localparam pos_t P_LN1 = 5'd5;
    localparam pos_t P_CR0 = 5'd6;
    localparam pos_t P_CR1 = 5'd7;
    localparam pos_t P_PK0 = 5'd8;
    localparam pos_t P_PKL = 5'd18;

    localparam crc_t CRC_REFL = 18'h23000;
    localparam logic [7:0] PID_DID  = 8'h41;
    localparam logic [7:0] PID_SDID = 8'h01;
    localparam logic [7:0] PID_DC   = 8'h04;

    function automatic crc_t crc_add(crc_t c, word_t w);
        crc_t r;
        logic fb;
        r = c;
        for (int b = 0; b < WORD_W; b++) begin
            fb = r[0] ^ w[b];
            r  = {1'b0, r[CRC_W-1:1]} ^ (fb ? CRC_REFL : '0);
        end
        return r;
    endfunction

    function automatic word_t byte_word(logic [7:0] u);
        return {~(^u), ^u, u};
    endfunction

    function automatic word_t ln_lo(logic [LN_W-1:0] l);
        return {~l[6], l[6:0], 2'b00};
    endfunction

    function automatic word_t ln_hi(logic [LN_W-1:0] l);
        return {1'b1, 3'b000, l[10:7], 2'b00};
    endfunction
endpackage

// File: rtl/sdi_pid_pkt.sv
module sdi_pid_pkt
    import sdi_pid_pkg::*;
(
    input  logic [UW_W-1:0]   uw,
    input  logic [PIDX_W-1:0] idx,
    output word_t             word
);
    word_t      body [PKT_LEN];
    logic [8:0] sum;

    always_comb begin
        body[0] = 10'h000;
        body[1] = 10'h3FF;
        body[2] = 10'h3FF;
        body[3] = byte_word(PID_DID);
        body[4] = byte_word(PID_SDID);
        body[5] = byte_word(PID_DC);
        for (int j = 0; j < 4; j++) begin
            body[6+j] = byte_word(uw[8*j +: 8]);
        end
        sum = '0;
        for (int j = 3; j < PKT_LEN-1; j++) begin
            sum = sum + body[j][8:0];
        end
        body[PKT_LEN-1] = {~sum[8], sum};
        word = (int'(idx) < PKT_LEN) ? body[int'(idx)] : 10'h000;
    end
endmodule

// File: rtl/sdi_pid_lane.sv
module sdi_pid_lane
    import sdi_pid_pkg::*;
#(
    parameter bit LUMA = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ce,
    input  logic            act,
    input  logic            ln_ok,
    input  logic            pid_en,
    input  logic            pid_c_en,
    input  logic [LN_W-1:0] ln,
    input  logic [LN_W-1:0] line_a,
    input  logic [LN_W-1:0] line_b,
    input  logic [UW_W-1:0] uw,
    input  word_t           din,
    output word_t           dout
);
    localparam word_t BLANK = LUMA ? 10'h040 : 10'h200;

    typedef struct packed {
        word_t           h0;
        word_t           h1;
        word_t           h2;
        pos_t            pos;
        crc_t            crc;
        logic            go;
        logic [LN_W-1:0] lnl;
        word_t           dout;
    } lane_st_t;

    lane_st_t st_d, st_q;
    word_t    pkt_w;
    logic [PIDX_W-1:0] pidx;

    assign pidx = PIDX_W'(st_q.pos - P_PK0);

    sdi_pid_pkt u_pkt (
        .uw   (uw),
        .idx  (pidx),
        .word (pkt_w)
    );

    logic  is_eav, in_slot, hit, start, go_now;
    word_t w;

    always_comb begin
        st_d    = st_q;
        is_eav  = (st_q.h2 == 10'h3FF) && (st_q.h1 == 10'h000) &&
                  (st_q.h0 == 10'h000) && din[6];
        in_slot = (st_q.pos >= P_PK0) && (st_q.pos <= P_PKL);
        hit     = (st_q.lnl == line_a) || (st_q.lnl == line_b);
        start   = act && pid_en && ln_ok && (LUMA || pid_c_en) && hit &&
                  (din == BLANK);
        go_now  = (st_q.pos == P_PK0) ? start : (in_slot && st_q.go);
        w       = din;
        if (act) begin
            if (st_q.pos == P_LN0 && ln_ok)      w = ln_lo(st_q.lnl);
            else if (st_q.pos == P_LN1 && ln_ok) w = ln_hi(st_q.lnl);
            else if (st_q.pos == P_CR0)          w = {~st_q.crc[8], st_q.crc[8:0]};
            else if (st_q.pos == P_CR1)          w = {~st_q.crc[17], st_q.crc[17:9]};
            else if (go_now)                     w = pkt_w;
        end
        if (ce) begin
            st_d.h0  = din;
            st_d.h1  = st_q.h0;
            st_d.h2  = st_q.h1;
            st_d.lnl = is_eav ? ln : st_q.lnl;
            st_d.go  = go_now;
            if (is_eav)
                st_d.pos = P_LN0;
            else if (st_q.pos >= P_LN0 && st_q.pos < P_PKL)
                st_d.pos = st_q.pos + 5'd1;
            else
                st_d.pos = '0;
            if (st_q.pos == P_CR1)
                st_d.crc = '0;
            else if (st_q.pos != P_CR0)
                st_d.crc = crc_add(st_q.crc, w);
            st_d.dout = w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.dout;

    // R2: no output change without the enable
    assert_hold_no_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(dout));

    // R9: unused lanes in four-stream mode are transparent
    assert_unused_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !act) |=> (dout == $past(din)));

    // R7: with insertion off, slot words are untouched
    assert_slot_untouched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !pid_en && st_q.pos >= P_PK0) |=> (dout == $past(din)));

    // R3: inserted first line word keeps its protection bit and zero LSBs
    assert_ln_format_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && act && ln_ok && st_q.pos == P_LN0) |=> (dout[9] == ~dout[8] && dout[1:0] == 2'b00));

    // R4: first CRC word has bit 9 inverted from bit 8
    assert_crc_format_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && act && st_q.pos == P_CR0) |=> (dout[9] == ~dout[8]));
endmodule

// File: rtl/sdi_pid_inserter.sv
module sdi_pid_inserter
    import sdi_pid_pkg::*;
#(
    parameter int NPAIR = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ce,
    input  logic                        mode8,
    input  logic                        ln_ok,
    input  logic                        pid_en,
    input  logic                        pid_c_en,
    input  logic [LN_W-1:0]             pid_line_a,
    input  logic [LN_W-1:0]             pid_line_b,
    input  logic [NPAIR*LN_W-1:0]       ln_in,
    input  logic [NPAIR*UW_W-1:0]       uw_y,
    input  logic [NPAIR*UW_W-1:0]       uw_c,
    input  logic [2*NPAIR*WORD_W-1:0]   din,
    output logic [2*NPAIR*WORD_W-1:0]   dout
);
    localparam int NLANE = 2 * NPAIR;
    localparam int NHALF = NLANE / 2;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam bit IS_Y = (g % 2) == 0;
        localparam int PR   = g / 2;
        logic act;
        assign act = mode8 || (g < NHALF);
        sdi_pid_lane #(.LUMA(IS_Y)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .ce       (ce),
            .act      (act),
            .ln_ok    (ln_ok),
            .pid_en   (pid_en),
            .pid_c_en (pid_c_en),
            .ln       (ln_in[PR*LN_W +: LN_W]),
            .line_a   (pid_line_a),
            .line_b   (pid_line_b),
            .uw       (IS_Y ? uw_y[PR*UW_W +: UW_W] : uw_c[PR*UW_W +: UW_W]),
            .din      (din[g*WORD_W +: WORD_W]),
            .dout     (dout[g*WORD_W +: WORD_W])
        );
    end
endmodule

// File: tb/sim_sdi_pid_inserter.sv
module sim_sdi_pid_inserter;
    localparam int NP = 4;
    localparam int NL = 8;
    localparam int LL = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, ce, mode8, ln_ok, pid_en, pid_c_en;
    logic [10:0] pid_line_a, pid_line_b;
    logic [NP*11-1:0] ln_in;
    logic [NP*32-1:0] uw_y, uw_c;
    logic [NL*10-1:0] din;
    logic [NL*10-1:0] dout;

    sdi_pid_inserter #(.NPAIR(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .ce(ce), .mode8(mode8), .ln_ok(ln_ok),
        .pid_en(pid_en), .pid_c_en(pid_c_en), .pid_line_a(pid_line_a),
        .pid_line_b(pid_line_b), .ln_in(ln_in), .uw_y(uw_y), .uw_c(uw_c),
        .din(din), .dout(dout)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [17:0] ecrc [NL];
    logic [9:0]  eout [NL];
    bit          go   [NL];
    bit          nb   [NL];
    logic [10:0] lnv  [NP];

    function automatic logic [17:0] m_crc(logic [17:0] c, logic [9:0] w);
        logic [17:0] r = c;
        for (int b = 0; b < 10; b++) begin
            if (r[0] ^ w[b]) r = (r >> 1) ^ 18'h23000;
            else             r = r >> 1;
        end
        return r;
    endfunction

    function automatic logic [9:0] m_byte(logic [7:0] u);
        logic p = ^u;
        return {~p, p, u};
    endfunction

    function automatic logic [9:0] m_pkt(logic [31:0] u, int j);
        logic [8:0] s;
        case (j)
            0: return 10'h000;
            1, 2: return 10'h3FF;
            3: return 10'h241;
            4: return 10'h101;
            5: return 10'h104;
            6, 7, 8, 9: return m_byte(u[8*(j-6) +: 8]);
            default: begin
                s = 9'h041 + 9'h101 + 9'h104;
                for (int q = 0; q < 4; q++) s = s + m_byte(u[8*q +: 8])[8:0];
                return {~s[8], s};
            end
        endcase
    endfunction

    function automatic logic [9:0] blank_of(int l);
        return (l % 2 == 0) ? 10'h040 : 10'h200;
    endfunction

    function automatic logic [9:0] in_word(int k, int i, int l);
        case (i)
            0: return 10'h3FF;
            1, 2: return 10'h000;
            3: return 10'h274;
            4: return 10'(10'h111 + l);
            5: return 10'h155;
            6: return 10'h222;
            7: return 10'h2AA;
            8: return nb[l] ? 10'h123 : blank_of(l);
            9, 10, 11, 12, 13, 14, 15, 16, 17, 18: return blank_of(l);
            19: return 10'h3FF;
            20, 21: return 10'h000;
            22: return 10'h200;
            default: return 10'(16 + ((k*7 + i*3 + l*11) % 976));
        endcase
    endfunction

    task automatic check(bit ok, string req, int l, logic [9:0] act_v, logic [9:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s stream %0d: got %03h expected %03h", req, l + 1, act_v, exp_v);
        end
    endtask

    // one word on every stream: drive at negedge, compare at the following negedge
    task automatic word_step(int k, int i, bit have_line);
        string tag [NL];
        logic [9:0] w;
        bit act, hit;
        logic [31:0] uw;
        for (int l = 0; l < NL; l++) begin
            act = mode8 || (l < NL/2);
            w   = have_line ? in_word(k, i, l) : 10'h040;
            din[l*10 +: 10] = w;
            eout[l] = w;
            tag[l]  = "R10";
            if (have_line) begin
                uw = (l % 2 == 0) ? uw_y[(l/2)*32 +: 32] : uw_c[(l/2)*32 +: 32];
                if (i == 8) begin
                    hit   = (lnv[l/2] == pid_line_a) || (lnv[l/2] == pid_line_b);
                    go[l] = act && pid_en && ln_ok && hit && (l % 2 == 0 || pid_c_en) &&
                            (w == blank_of(l));
                end
                if (!act) tag[l] = "R9";
                else if (i == 4 || i == 5) begin
                    tag[l] = "R3";
                    if (ln_ok) eout[l] = (i == 4) ? {~lnv[l/2][6], lnv[l/2][6:0], 2'b00}
                                                  : {1'b1, 3'b000, lnv[l/2][10:7], 2'b00};
                end else if (i == 6) begin
                    tag[l] = "R4"; eout[l] = {~ecrc[l][8], ecrc[l][8:0]};
                end else if (i == 7) begin
                    tag[l] = "R4"; eout[l] = {~ecrc[l][17], ecrc[l][17:9]};
                end else if (i >= 8 && i <= 18) begin
                    if (go[l]) begin
                        eout[l] = m_pkt(uw, i - 8);
                        tag[l]  = (l % 2 == 0) ? "R5" : "R6";
                    end else if (!pid_en || !ln_ok ||
                                 !((lnv[l/2] == pid_line_a) || (lnv[l/2] == pid_line_b)))
                        tag[l] = "R7";
                    else if (nb[l]) tag[l] = "R8";
                    else tag[l] = "R6";
                end
                if (i == 7)      ecrc[l] = '0;
                else if (i != 6) ecrc[l] = m_crc(ecrc[l], eout[l]);
            end else begin
                ecrc[l] = m_crc(ecrc[l], eout[l]);
            end
        end
        ce = 1'b1;
        @(posedge clk);
        @(negedge clk);
        for (int l = 0; l < NL; l++)
            check(dout[l*10 +: 10] == eout[l], tag[l], l, dout[l*10 +: 10], eout[l]);
        if (mode8) begin
            ce  = 1'b0;
            din = {NL{10'h3FF}};
            @(posedge clk);
            @(negedge clk);
            for (int l = 0; l < NL; l++)   // R2: hold while enable low
                check(dout[l*10 +: 10] == eout[l], "R2", l, dout[l*10 +: 10], eout[l]);
        end
    endtask

    task automatic run_line(int k, int base);
        for (int p = 0; p < NP; p++) begin
            lnv[p] = 11'(base + k + p);
            ln_in[p*11 +: 11] = lnv[p];
            uw_y[p*32 +: 32] = {8'(k + p), 8'(3*k), 8'(8'h80 | p), 8'(k*5 + 1)};
            uw_c[p*32 +: 32] = {8'(8'hF0 ^ k), 8'(p*9), 8'(k*k), 8'(8'h3C + p)};
        end
        for (int l = 0; l < NL; l++) nb[l] = ((k + l) % 4 == 3);
        ln_ok    = (k % 7 != 6);
        pid_en   = (k % 5 != 4);
        pid_c_en = k[0];
        for (int i = 0; i < LL; i++) word_step(k, i, 1'b1);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ce = 1'b0; mode8 = 1'b1; ln_ok = 1'b1; pid_en = 1'b1; pid_c_en = 1'b0;
        pid_line_a = 11'd5; pid_line_b = 11'd9;
        ln_in = '0; uw_y = '0; uw_c = '0; din = '0;
        for (int l = 0; l < NL; l++) begin ecrc[l] = '0; go[l] = 1'b0; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        for (int l = 0; l < NL; l++)   // R1: reset value
            check(dout[l*10 +: 10] == 10'h000, "R1", l, dout[l*10 +: 10], 10'h000);
        for (int i = 0; i < 6; i++) word_step(0, i, 1'b0);
        // eight-stream sweep over lines, gating and blanking patterns
        for (int k = 1; k <= 20; k++) run_line(k, 0);
        // four-stream mode, large line numbers, upper streams transparent (R9)
        mode8 = 1'b0; pid_line_a = 11'd1525; pid_line_b = 11'd1530;
        for (int k = 21; k <= 30; k++) run_line(k, 1500);
        // back to eight streams near the top of the line range
        mode8 = 1'b1; pid_line_a = 11'd2012; pid_line_b = 11'd2043;
        for (int k = 31; k <= 34; k++) run_line(k, 1978);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule